// File: doc/BRIEF.md
# Serial Overhead Frame Parity Insert and Check

This block protects one channel of a bit-serial transport-overhead stream with a single even-parity bit carried inside the frame. On the transmit path it watches the outgoing bits. It folds every bit of a frame into a running parity, except the frame's first bit. It then writes that parity into the first bit of the following frame. The first bit is the most significant bit of the first framing byte of the first tributary, sent MSB first.

On the receive path the same position tracking runs over the incoming stream. At the head of each frame, the embedded bit is compared with the parity gathered over the previous frame. A disagreement raises a one-cycle error pulse and sets a sticky alarm. The alarm stays set until a clear strobe arrives.

Frame length comes from parameters: tributary count × rows × overhead columns × 8 bits. A frame-start input realigns the position counter at any time. Between starts the counter wraps by itself. Each direction keeps its own counter.

Top module: `toh_par_top`

## Requirements
- R1: A frame is FRAME_BITS = STS_COUNT*ROWS*COLS*8 bits long. Once a frame-start has been seen, a new frame head occurs either on a frame-start or FRAME_BITS bits after the previous head, whichever comes first.
- R2: The reserved parity bit is position 0 of each frame, which is the bit presented together with the frame-start or at the wrap.
- R3: On the transmit path every non-reserved bit appears unchanged on txOutBit one clock later. txOutStart equals txFrameStart delayed by one clock.
- R4: The transmit reserved bit of each frame after the first equals the XOR of bits 1 to the end of the previous frame. This makes the previous frame's covered bits plus the inserted bit even.
- R5: The reserved bit of the first frame after reset is sent as 0. Bits before the first frame-start pass through unchanged.
- R6: At each receive frame head except the first after reset, the bit at position 0 is compared with the XOR of bits 1 to the end of the previous receive frame. A mismatch pulses parityErr high for one cycle, one clock after the head bit.
- R7: alarm rises in the same cycle as parityErr and then stays high.
- R8: An alarmClear pulse drops alarm one clock later, unless a mismatch is detected in the same input cycle, in which case alarm stays high.
- R9: While reset is held, and in the first cycle after it, txOutBit, txOutStart, parityErr and alarm are 0.
- R10: A frame-start arriving before FRAME_BITS bits have elapsed ends the current frame early. That frame's parity covers only the bits received after its head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| txBit | input | 1 | Transmit serial bit in |
| txFrameStart | input | 1 | Marks the first bit of a transmit frame |
| txOutBit | output | 1 | Transmit serial bit out, parity inserted |
| txOutStart | output | 1 | Frame-start aligned with txOutBit |
| rxBit | input | 1 | Receive serial bit |
| rxFrameStart | input | 1 | Marks the first bit of a receive frame |
| alarmClear | input | 1 | One-cycle strobe clearing the alarm |
| parityErr | output | 1 | One-cycle pulse per detected mismatch |
| alarm | output | 1 | Sticky parity alarm |

## Verification
The checker watches the alarm protocol on every cycle:
- alarm rises only together with parityErr;
- alarm holds without a clear;
- alarm falls after a clear unless an error arrives in that cycle;
- the start marker is delayed by one clock;
- reset leaves the outputs quiet.

Only the bench scenarios can show the following:
- the parity value written into each frame is correct;
- the correct position is chosen after wraps and after early frame-starts;
- the first frame is skipped;
- a corrupted receive frame is actually detected.

To show these, the bench compares each output bit against a reference model built from the requirements.

// File: rtl/toh_par_pkg.sv
package toh_par_pkg;
  // Position strobes handed from a direction's control to the datapath
  typedef struct packed {
    logic head;     // current bit is the reserved position 0
    logic haveRef;  // a full previous frame has been accumulated
    logic tracking; // a frame-start has been seen since reset
  } posStrobe_t;

  localparam int NUM_DIR = 2;
  localparam int DIR_TX  = 0;
  localparam int DIR_RX  = 1;
endpackage

// File: rtl/toh_par_ctrl.sv
module toh_par_ctrl
  import toh_par_pkg::*;
#(
  parameter int FRAME_BITS = 2592
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frameStart,
  output posStrobe_t strb
);
  localparam int CW = (FRAME_BITS > 2) ? $clog2(FRAME_BITS) : 1;
  localparam logic [CW-1:0] LAST_POS = CW'(FRAME_BITS - 1);

  logic [CW-1:0] nextPos;   // position the next bit will take
  logic          synced;
  logic          headNow;

  // R1/R2/R10: head on a start marker or on counter wrap once aligned
  assign headNow = frameStart || (synced && (nextPos == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      nextPos <= '0;
      synced  <= 1'b0;
    end else begin
      if (headNow) begin
        nextPos <= (FRAME_BITS > 1) ? CW'(1) : '0;
      end else if (synced) begin
        nextPos <= (nextPos == LAST_POS) ? '0 : nextPos + CW'(1);
      end
      if (frameStart) synced <= 1'b1;
    end
  end

  always_comb begin
    strb.head     = headNow;
    strb.haveRef  = headNow && synced;
    strb.tracking = synced;
  end
endmodule

// File: rtl/toh_par_dp.sv
module toh_par_dp
  import toh_par_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  posStrobe_t txStrb,
  input  posStrobe_t rxStrb,
  input  logic       txBit,
  input  logic       txFrameStart,
  input  logic       rxBit,
  input  logic       alarmClear,
  output logic       txOutBit,
  output logic       txOutStart,
  output logic       parityErr,
  output logic       alarm
);
  logic txAcc, rxAcc;
  logic txNextBit;
  logic mismatch;

  // Transmit: running even parity, cleared on the reserved bit
  always_ff @(posedge clk) begin
    if (rst) txAcc <= 1'b0;
    else if (txStrb.head) txAcc <= 1'b0;
    else txAcc <= txAcc ^ txBit;
  end

  // R4/R5: reserved bit carries previous frame parity, 0 with no reference
  always_comb begin
    if (txStrb.head) txNextBit = txStrb.haveRef ? txAcc : 1'b0;
    else txNextBit = txBit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txOutBit   <= 1'b0;
      txOutStart <= 1'b0;
    end else begin
      txOutBit   <= txNextBit;
      txOutStart <= txFrameStart;
    end
  end

  // Receive: same accumulation, compare at each referenced head
  always_ff @(posedge clk) begin
    if (rst) rxAcc <= 1'b0;
    else if (rxStrb.head) rxAcc <= 1'b0;
    else rxAcc <= rxAcc ^ rxBit;
  end

  assign mismatch = rxStrb.haveRef && (rxBit != rxAcc);

  // R6/R7/R8: error pulse and sticky alarm, error beats clear
  always_ff @(posedge clk) begin
    if (rst) begin
      parityErr <= 1'b0;
      alarm     <= 1'b0;
    end else begin
      parityErr <= mismatch;
      if (mismatch) alarm <= 1'b1;
      else if (alarmClear) alarm <= 1'b0;
    end
  end
endmodule

// File: rtl/toh_par_top.sv
module toh_par_top
  import toh_par_pkg::*;
#(
  parameter int STS_COUNT = 12,
  parameter int ROWS      = 9,
  parameter int COLS      = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic txBit,
  input  logic txFrameStart,
  output logic txOutBit,
  output logic txOutStart,
  input  logic rxBit,
  input  logic rxFrameStart,
  input  logic alarmClear,
  output logic parityErr,
  output logic alarm
);
  localparam int FRAME_BITS = STS_COUNT * ROWS * COLS * 8;

  posStrobe_t dirStrb [NUM_DIR];
  logic       dirStart [NUM_DIR];

  assign dirStart[DIR_TX] = txFrameStart;
  assign dirStart[DIR_RX] = rxFrameStart;

  for (genvar gi = 0; gi < NUM_DIR; gi++) begin : g_dir
    toh_par_ctrl #(.FRAME_BITS(FRAME_BITS)) u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .frameStart(dirStart[gi]),
      .strb      (dirStrb[gi])
    );
  end

  toh_par_dp u_dp (
    .clk         (clk),
    .rst         (rst),
    .txStrb      (dirStrb[DIR_TX]),
    .rxStrb      (dirStrb[DIR_RX]),
    .txBit       (txBit),
    .txFrameStart(txFrameStart),
    .rxBit       (rxBit),
    .alarmClear  (alarmClear),
    .txOutBit    (txOutBit),
    .txOutStart  (txOutStart),
    .parityErr   (parityErr),
    .alarm       (alarm)
  );
endmodule

// File: rtl/toh_par_chk.sv
module toh_par_chk (
  input logic clk,
  input logic rst,
  input logic txFrameStart,
  input logic txOutStart,
  input logic txOutBit,
  input logic alarmClear,
  input logic parityErr,
  input logic alarm
);
  a_r7_rise_with_err: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm) |-> parityErr);

  a_r7_err_sets_alarm: assert property (@(posedge clk) disable iff (rst)
    parityErr |-> alarm);

  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (alarm && !alarmClear) |=> alarm);

  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    alarmClear |=> (!alarm || parityErr));

  a_r3_start_delay: assert property (@(posedge clk) disable iff (rst)
    txFrameStart |=> txOutStart);

  a_r9_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!alarm && !parityErr && !txOutStart && !txOutBit));
endmodule

bind toh_par_top toh_par_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .txFrameStart(txFrameStart),
  .txOutStart  (txOutStart),
  .txOutBit    (txOutBit),
  .alarmClear  (alarmClear),
  .parityErr   (parityErr),
  .alarm       (alarm)
);

// File: tb/toh_par_top_bench.sv
module toh_par_top_bench;
  localparam int STS = 1;
  localparam int FB  = STS * 9 * 3 * 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic txBit = 1'b0, txFrameStart = 1'b0, rxBit = 1'b0, rxFrameStart = 1'b0;
  logic alarmClear = 1'b0;
  logic txOutBit, txOutStart, parityErr, alarm;

  always #2 clk = ~clk;

  toh_par_top #(.STS_COUNT(STS), .ROWS(9), .COLS(3)) u_toh_par_top (
    .clk(clk), .rst(rst),
    .txBit(txBit), .txFrameStart(txFrameStart),
    .txOutBit(txOutBit), .txOutStart(txOutStart),
    .rxBit(rxBit), .rxFrameStart(rxFrameStart),
    .alarmClear(alarmClear),
    .parityErr(parityErr), .alarm(alarm)
  );

  typedef struct {
    logic  eTx, eStart, eErr, eAlarm;
    string tagTx, tagAlarm;
  } expItem_t;

  expItem_t q[$];
  expItem_t it;
  int checks = 0, fails = 0;

  // reference model state
  int tPos = 0, rPos = 0;
  bit tSync = 0, rSync = 0, tAcc = 0, rAcc = 0, alarmM = 0;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: compare results one step after the driven cycle
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      it = q.pop_front();
      chk(it.tagTx, txOutBit, it.eTx);
      chk("R3 start", txOutStart, it.eStart);
      chk("R6 err", parityErr, it.eErr);
      chk(it.tagAlarm, alarm, it.eAlarm);
    end
  end

  task automatic step(input bit b, input bit s, input bit rb, input bit rs, input bit clr);
    expItem_t e;
    bit tHead, rHead, mism;
    @(negedge clk);
    txBit = b; txFrameStart = s; rxBit = rb; rxFrameStart = rs; alarmClear = clr;
    // transmit model
    tHead = s || (tSync && tPos == 0);
    if (tHead) begin
      e.eTx = tSync ? tAcc : 1'b0;
      e.tagTx = s ? ((tSync && tPos != 0) ? "R10" : "R2") : "R1";
      e.tagTx = {e.tagTx, tSync ? "/R4 parity" : "/R5 first"};
    end else begin
      e.eTx = b;
      e.tagTx = tSync ? "R3 pass" : "R5 presync";
    end
    if (tHead) begin tAcc = 0; tPos = 1; end
    else begin tAcc ^= b; if (tSync) tPos = (tPos == FB-1) ? 0 : tPos + 1; end
    if (s) tSync = 1;
    e.eStart = s;
    // receive model
    rHead = rs || (rSync && rPos == 0);
    mism = rHead && rSync && (rb != rAcc);
    if (rHead) begin rAcc = 0; rPos = 1; end
    else begin rAcc ^= rb; if (rSync) rPos = (rPos == FB-1) ? 0 : rPos + 1; end
    if (rs) rSync = 1;
    e.eErr = mism;
    e.tagAlarm = clr ? "R8 alarm" : "R7 alarm";
    if (mism) alarmM = 1; else if (clr) alarmM = 0;
    e.eAlarm = alarmM;
    q.push_back(e);
  endtask

  // one frame on both directions; rx head carries correct or flipped parity
  task automatic frame(input bit useStart, input int len, input bit corrupt,
                       input bit clrAtHead, input bit clrMid);
    for (int i = 0; i < len; i++) begin
      bit rb;
      rb = (i == 0) ? (rAcc ^ corrupt) : 1'($urandom);
      step(1'($urandom), useStart && i == 0, rb, useStart && i == 0,
           (i == 0 && clrAtHead) || (i == 5 && clrMid));
    end
  endtask

  initial begin
    #150000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: outputs quiet during reset
    chk("R9 txOutBit", txOutBit, 1'b0);
    chk("R9 txOutStart", txOutStart, 1'b0);
    chk("R9 parityErr", parityErr, 1'b0);
    chk("R9 alarm", alarm, 1'b0);
    rst = 1'b0;
    for (int i = 0; i < 5; i++) step(1'($urandom), 0, 1'($urandom), 0, 0); // R5 presync
    frame(1, FB, 0, 0, 0);   // first frame, no reference
    frame(0, FB, 0, 0, 0);   // R1 wrap heads
    frame(0, FB, 0, 0, 0);
    frame(0, FB, 1, 0, 0);   // R6 corrupted head
    frame(0, FB, 0, 0, 1);   // R8 clear mid frame
    frame(0, FB, 1, 1, 0);   // R8 error beats clear
    frame(1, FB, 0, 0, 1);   // restart aligned, clear
    frame(1, 50, 0, 0, 0);   // R10 short frame
    frame(1, FB, 0, 0, 0);
    frame(0, FB, 1, 0, 0);   // error after realign
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    #2;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule